// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Completion Accounting

This block holds the interrupt registers of one DMA channel. The transfer engine sends single-cycle event pulses. The block latches them into a sticky status register, and software clears that register with write-1-to-clear. A separate mask register hides chosen status bits from the single level interrupt output. Software never writes the mask directly. It sets mask bits through a disable register and clears them through an enable register, so two agents can change different bits without a read-modify-write race.

Two 8-bit counters track source-side and destination-side completion events. A read returns the current count and zeroes the counter in the same access. A counter that is already full saturates, and the lost increment sets an accounting-error status bit. Software reaches the block over a simple 32-bit register bus. A request is one cycle with `req_i` high, and read data appears on `rdata_o` in the following cycle.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset, status reads 0, the mask reads 0x7FD (every implemented bit set), both counters read 0, `irq_o` is low and `rdata_o` is 0.
- R2: A pulse on `evt_i[k]` sets status bit k for k in {10 done, 9 write-data error, 8 read-data error, 7 destination-descriptor error, 6 source-descriptor error, 3 byte-count overflow, 2 destination-descriptor done}. Pulses on `evt_i` bits 0, 1, 4 and 5 are ignored. Status bit 1 and bits 31:11 of every register read 0.
- R3: A write to offset 0x100 clears each status bit whose `wdata_i` bit is 1 and leaves the other bits unchanged.
- R4: When an event arrives in the same cycle as a write-1-to-clear of its own bit, the event wins and the bit stays set.
- R5: Writing 1s to offset 0x10C sets the matching mask bits, and writing 1s to offset 0x108 clears them. Offset 0x104 reads the mask, and writes to 0x104 are ignored. Writing 0xFFF to 0x10C masks every source.
- R6: `irq_o` is high exactly when some status bit is set while its mask bit is 0. It is a level that stays high until those bits are cleared or masked. A masked event is still recorded in status and raises `irq_o` once it is unmasked.
- R7: Each `src_done_i` pulse increments the counter at 0x190, and each `dst_done_i` pulse increments the counter at 0x194. Reading either counter returns its value and resets it to 0. Writes to these offsets are ignored.
- R8: Both counters saturate at 255. An increment while the source counter is at 255 sets status bit 4, and an increment while the destination counter is at 255 sets status bit 5.
- R9: A write to any offset other than 0x100, 0x104, 0x108, 0x10C, 0x190 or 0x194 sets status bit 0. A read of such an offset returns 0 and has no other effect.
- R10: `rdata_o` is registered. It takes the value read in the cycle after the request and holds it until the next read. When an increment coincides with a read of its counter, the read returns the old value and the counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| evt_i | input | 11 | Event pulses from the transfer engine, one per status bit |
| src_done_i | input | 1 | Source-side completion pulse |
| dst_done_i | input | 1 | Destination-side completion pulse |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench drives an event and a clear of the same bit in one cycle. A design that gives the clear priority would lose the event and leave `irq_o` low. The counters are pushed past 255. A wrapping counter would read back a small value and never set bit 4 or 5. A read is issued in the same cycle as a completion pulse. A design that zeroes the counter after adding the increment would read back 0 afterwards instead of 1. Other stimulus covers:
- masking an event before it arrives and then unmasking it, to expose an interrupt that is gated at the event instead of at the output;
- writes to the read-only mask and counter offsets, which must change nothing;
- writes to unmapped offsets, which must set only bit 0.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_BITS = 11;
  localparam int ADDR_W   = 12;

  localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_UNMASK  = 12'h108;
  localparam logic [ADDR_W-1:0] OFS_SETMASK = 12'h10C;
  localparam logic [ADDR_W-1:0] OFS_SRC_CNT = 12'h190;
  localparam logic [ADDR_W-1:0] OFS_DST_CNT = 12'h194;

  localparam int BIT_BAD_ACC   = 0;
  localparam int BIT_SRC_ACCT  = 4;
  localparam int BIT_DST_ACCT  = 5;

  // bits that exist in status and mask; bits the engine may raise directly
  localparam logic [NUM_BITS-1:0] IMPL_BITS = 11'h7FD;
  localparam logic [NUM_BITS-1:0] EVT_BITS  = 11'h7CC;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_MASK, SEL_UNMASK, SEL_SETMASK, SEL_SRC, SEL_DST
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int                NUM_BITS = 11,
  parameter logic [NUM_BITS-1:0] RST_MASK = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_BITS-1:0] set_i,
  input  logic [NUM_BITS-1:0] clr_i,
  input  logic [NUM_BITS-1:0] mask_set_i,
  input  logic [NUM_BITS-1:0] mask_clr_i,
  output logic [NUM_BITS-1:0] status_o,
  output logic [NUM_BITS-1:0] mask_o,
  output logic                irq_o
);
  logic [NUM_BITS-1:0] status_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= RST_MASK;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;  // set beats clear
      mask_q   <= (mask_q | mask_set_i) & ~mask_clr_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  p_set_sticks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  p_clear_takes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));

  p_mask_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_set_i != '0) |=> ((mask_q & $past(mask_set_i)) == $past(mask_set_i)));

  p_irq_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && clr_i == '0 && mask_set_i == '0) |=> irq_o);
endmodule

// File: rtl/dma_irq_acct.sv
module dma_irq_acct #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, base, cnt_d;

  always_comb begin
    base  = rd_clr_i ? '0 : cnt_q;
    cnt_d = (inc_i && base != CNT_MAX) ? base + 1'b1 : base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = inc_i && !rd_clr_i && (cnt_q == CNT_MAX);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !inc_i) |=> (cnt_q == '0));

  p_read_inc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && inc_i) |=> (cnt_q == 1));

  p_saturate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !rd_clr_i) |=> (cnt_q == CNT_MAX));

  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !rd_clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_BITS-1:0] evt_i,
  input  logic                src_done_i,
  input  logic                dst_done_i,
  output logic                irq_o
);
  localparam int NUM_CNT = 2;

  reg_sel_e            sel;
  logic                wr, rd, bad_wr;
  logic [NUM_BITS-1:0] wbits, set_vec, clr_vec, mset, mclr, status, mask;
  logic [NUM_CNT-1:0]  inc, rclr, ovf;
  logic [CNT_W-1:0]    cnt [NUM_CNT];
  logic [DATA_W-1:0]   rd_val, rdata_q;
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_BITS];

  always_comb begin
    unique case (addr_i)
      OFS_STATUS:  sel = SEL_STATUS;
      OFS_MASK:    sel = SEL_MASK;
      OFS_UNMASK:  sel = SEL_UNMASK;
      OFS_SETMASK: sel = SEL_SETMASK;
      OFS_SRC_CNT: sel = SEL_SRC;
      OFS_DST_CNT: sel = SEL_DST;
      default:     sel = SEL_NONE;
    endcase
  end

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign bad_wr = wr && (sel == SEL_NONE);
  assign wbits  = wdata_i[NUM_BITS-1:0] & IMPL_BITS;

  assign inc  = {dst_done_i, src_done_i};
  assign rclr = {rd && (sel == SEL_DST), rd && (sel == SEL_SRC)};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_acct
    dma_irq_acct #(.CNT_W(CNT_W)) u_acct (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (inc[i]),
      .rd_clr_i (rclr[i]),
      .cnt_o    (cnt[i]),
      .ovf_o    (ovf[i])
    );
  end

  always_comb begin
    set_vec = evt_i & EVT_BITS;
    set_vec[BIT_BAD_ACC]  = bad_wr;
    set_vec[BIT_SRC_ACCT] = ovf[0];
    set_vec[BIT_DST_ACCT] = ovf[1];
  end

  assign clr_vec = (wr && sel == SEL_STATUS)  ? wbits : '0;
  assign mset    = (wr && sel == SEL_SETMASK) ? wbits : '0;
  assign mclr    = (wr && sel == SEL_UNMASK)  ? wbits : '0;

  dma_irq_status #(.NUM_BITS(NUM_BITS), .RST_MASK(IMPL_BITS)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_i      (clr_vec),
    .mask_set_i (mset),
    .mask_clr_i (mclr),
    .status_o   (status),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_val = '0;
    unique case (sel)
      SEL_STATUS: rd_val[NUM_BITS-1:0] = status;
      SEL_MASK:   rd_val[NUM_BITS-1:0] = mask;
      SEL_SRC:    rd_val[CNT_W-1:0]    = cnt[0];
      SEL_DST:    rd_val[CNT_W-1:0]    = cnt[1];
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  p_bad_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> status[BIT_BAD_ACC]);

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:NUM_BITS] == '0);

  p_ovf_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc[0] && !rclr[0] && cnt[0] == '1) |=> status[BIT_SRC_ACCT]);
endmodule

// File: tb/sim_dma_irq_bank.sv
module sim_dma_irq_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [10:0] evt = '0;
  logic        sd = 1'b0, dd = 1'b0;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  int m_stat = 0, m_mask = 'h7FD, m_src = 0, m_dst = 0, m_rdata = 0;
  bit m_irq = 0;

  always #5 clk = ~clk;

  dma_irq_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .src_done_i(sd),
    .dst_done_i(dd), .irq_o(irq)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit mapped(input int a);
    return a == 'h100 || a == 'h104 || a == 'h108 || a == 'h10C ||
           a == 'h190 || a == 'h194;
  endfunction

  function automatic int rdval(input int a);
    case (a)
      'h100:   return m_stat;
      'h104:   return m_mask;
      'h190:   return m_src;
      'h194:   return m_dst;
      default: return 0;
    endcase
  endfunction

  // one bus/event cycle: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input bit rq, input bit w, input int a, input int d,
                     input int e, input bit s, input bit t, input string tag);
    int set, clr, n_stat, n_mask, n_src, n_dst, n_rd;
    bit rd_s, rd_d, wr, rd;
    req = rq; we = w; addr = a[11:0]; wdata = d; evt = e[10:0]; sd = s; dd = t;
    wr = rq && w; rd = rq && !w;
    rd_s = rd && a == 'h190; rd_d = rd && a == 'h194;
    set = e & 'h7CC;
    if (wr && !mapped(a)) set |= 'h1;
    if (s && !rd_s && m_src == 255) set |= 'h10;
    if (t && !rd_d && m_dst == 255) set |= 'h20;
    clr = (wr && a == 'h100) ? (d & 'h7FD) : 0;
    n_stat = (m_stat & ~clr) | set;
    n_mask = m_mask;
    if (wr && a == 'h10C) n_mask = n_mask | (d & 'h7FD);
    if (wr && a == 'h108) n_mask = n_mask & ~d & 'h7FD;
    n_src = rd_s ? 0 : m_src; if (s && n_src < 255) n_src++;
    n_dst = rd_d ? 0 : m_dst; if (t && n_dst < 255) n_dst++;
    n_rd = rd ? rdval(a) : m_rdata;
    @(posedge clk);
    @(negedge clk);
    m_stat = n_stat; m_mask = n_mask; m_src = n_src; m_dst = n_dst; m_rdata = n_rd;
    m_irq = (m_stat & ~m_mask) != 0;
    req = 0; we = 0; evt = '0; sd = 0; dd = 0;
    chk(tag, "irq_o", int'(irq), int'(m_irq));
    chk(tag, "rdata_o", rdata, m_rdata);
  endtask

  task automatic rd_reg(input int a, input string tag);
    cyc(1, 0, a, 0, 0, 0, 0, tag);
  endtask
  task automatic wr_reg(input int a, input int d, input string tag);
    cyc(1, 1, a, d, 0, 0, 0, tag);
  endtask
  task automatic pulse(input int e, input bit s, input bit t, input string tag);
    cyc(0, 0, 0, 0, e, s, t, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "irq_o in reset", int'(irq), 0);
    chk("R1", "rdata_o in reset", rdata, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset contents
    rd_reg('h100, "R1"); rd_reg('h104, "R1");
    rd_reg('h190, "R1"); rd_reg('h194, "R1");
    // R2 events captured while masked; internal-only bits ignored
    pulse('h7CC, 0, 0, "R2");
    pulse('h033, 0, 0, "R2");
    rd_reg('h100, "R2");
    // R5 enable all, R6 irq rises
    wr_reg('h108, 'h7FF, "R5");
    rd_reg('h104, "R5");
    // R3 write-1-to-clear, write back value read
    wr_reg('h100, 'h004, "R3");
    rd_reg('h100, "R3");
    wr_reg('h100, 'h7C8, "R3");
    rd_reg('h100, "R3");
    // R4 event and clear of same bit collide
    cyc(1, 1, 'h100, 'h400, 'h400, 0, 0, "R4");
    rd_reg('h100, "R4");
    cyc(1, 1, 'h100, 'h408, 'h008, 0, 0, "R4");
    wr_reg('h100, 'h7FF, "R4");
    // R6 masked event recorded, then unmasked
    wr_reg('h10C, 'h200, "R6");
    pulse('h200, 0, 0, "R6");
    pulse(0, 0, 0, "R6");
    rd_reg('h100, "R6");
    wr_reg('h108, 'h200, "R6");
    pulse(0, 0, 0, "R6");
    wr_reg('h100, 'h200, "R6");
    // R9 unmapped accesses, R5 writes to mask ignored, R7 writes to counters ignored
    rd_reg('h200, "R9");
    rd_reg('h100, "R9");
    wr_reg('h200, 'h7FF, "R9");
    rd_reg('h100, "R9");
    wr_reg('h104, 'h7FD, "R5");
    rd_reg('h104, "R5");
    wr_reg('h190, 'h55, "R7");
    rd_reg('h190, "R7");
    wr_reg('h100, 'h001, "R9");
    // R7 counting and clear-on-read
    for (int i = 0; i < 5; i++) pulse(0, 1, i < 3, "R7");
    rd_reg('h190, "R7"); rd_reg('h190, "R7");
    rd_reg('h194, "R7");
    // R10 read coinciding with increment
    pulse(0, 1, 1, "R10");
    cyc(1, 0, 'h190, 0, 0, 1, 0, "R10");
    rd_reg('h190, "R10");
    cyc(1, 0, 'h194, 0, 0, 0, 1, "R10");
    rd_reg('h194, "R10");
    // R8 saturation and accounting errors
    for (int i = 0; i < 260; i++) pulse(0, 1, 0, "R8");
    rd_reg('h100, "R8");
    rd_reg('h190, "R8");
    for (int i = 0; i < 257; i++) pulse(0, 0, 1, "R8");
    rd_reg('h100, "R8");
    rd_reg('h194, "R8");
    rd_reg('h194, "R8");
    // R5 mask everything while bits pending
    pulse('h404, 0, 0, "R5");
    wr_reg('h10C, 'hFFF, "R5");
    rd_reg('h104, "R5");
    rd_reg('h100, "R5");
    wr_reg('h108, 'h004, "R6");
    wr_reg('h100, 'h7FF, "R3");
    rd_reg('h100, "R3");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule